// File: doc/BRIEF.md
# Dual-Group Pin Debounce Filter

This block removes chatter from eight input pins, handled as two independent groups of four. Each group has its own 3-bit window code. The code selects a check window, counted either in pulses of a slow clock-enable strobe or in pulses of a fast clock-enable strobe, or it turns the filter off so the pins pass straight through. Both strobes are single-cycle enables on the one system clock. The filtered levels normally feed an edge detector that raises interrupts, so a burst of bounce on a key or switch produces one clean transition.

Within a group, a free-running window counter emits one tick per window. Each tick samples the pins. A pin's filtered level moves to a new value only when two consecutive tick samples agree on it. A pulse no longer than one window can reach at most one tick, so it is dropped. A level held for two windows always spans two ticks, so it is taken. When a group's code changes, its counter restarts and any tick due in that cycle is discarded. The first tick of the new window only captures a reference sample, so the filtered outputs hold their last value until the new window has run.

Top module: `dual_nibble_debounce`

## Requirements
- R1: After a synchronous reset, with a non-zero code applied to a group, that group's filtered outputs read 0 regardless of the pin levels, until the filter accepts a level.
- R2: With code 000, a group's filtered outputs equal its raw pins in the same cycle, with no level check.
- R3: Codes 101, 110 and 111 set a window of 1, 2 and 4 fast-strobe pulses respectively.
- R4: Codes 001, 010, 011 and 100 set a window of 128, 512, 2048 and 4096 slow-strobe pulses respectively.
- R5: A pin pulse that lasts no longer than one window never appears at the filtered output.
- R6: A pin level held for at least two windows appears at the filtered output by the end of that hold.
- R7: A filtered output changes only on a window tick at which the pin agrees with the previous tick's sample, or while the code is 000.
- R8: A code change restarts the window counter, discards a tick due in that cycle, and makes the first tick of the new window only capture a reference sample. The outputs hold their value until then.
- R9: Pins 0-3 use code bits 2:0 and pins 4-7 use code bits 5:3. Neither group's code or pins affect the other group.
- R10: The window counts only the strobe of the selected source. Pulses on the other strobe have no effect on the window length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_stb | input | 1 | Single-cycle enable from the slow clock divider |
| fast_stb | input | 1 | Single-cycle enable from the fast clock divider |
| win_code | input | 6 | Window codes: bits 2:0 for pins 0-3, bits 5:3 for pins 4-7 |
| pin_raw | input | 8 | Raw pin levels, already synchronous to clk |
| pin_clean | output | 8 | Filtered pin levels |

## Verification
Two functions can fall in the same cycle: a code change, and a window tick of the old window that is due in that cycle. The bench provokes this by running the fastest code, which ticks on every cycle, and then changing both the code and the pin levels on the same edge. The stale tick would otherwise sample the new pin level and, together with the restarted window's first tick, release it early. The check passes if the output keeps its old level across the discarded tick and the priming tick, and takes the new level only after the second tick of the new window.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_FAST = 2'd2
    } win_src_e;

    typedef struct packed {
        win_src_e   src;
        logic [1:0] step;
    } win_sel_t;

    function automatic win_sel_t decode_code(input logic [2:0] code);
        win_sel_t s;
        case (code)
            3'b001:  s = '{src: SRC_SLOW, step: 2'd0};
            3'b010:  s = '{src: SRC_SLOW, step: 2'd1};
            3'b011:  s = '{src: SRC_SLOW, step: 2'd2};
            3'b100:  s = '{src: SRC_SLOW, step: 2'd3};
            3'b101:  s = '{src: SRC_FAST, step: 2'd0};
            3'b110:  s = '{src: SRC_FAST, step: 2'd1};
            3'b111:  s = '{src: SRC_FAST, step: 2'd2};
            default: s = '{src: SRC_OFF,  step: 2'd0};
        endcase
        return s;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbn_window_timer.sv
module dbn_window_timer
    import dbn_pkg::*;
#(
    parameter int unsigned SLOW_DIV0 = 128,
    parameter int unsigned SLOW_DIV1 = 512,
    parameter int unsigned SLOW_DIV2 = 2048,
    parameter int unsigned SLOW_DIV3 = 4096,
    parameter int unsigned FAST_DIV0 = 1,
    parameter int unsigned FAST_DIV1 = 2,
    parameter int unsigned FAST_DIV2 = 4,
    parameter int unsigned CNT_W     = 13
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     slow_stb,
    input  logic     fast_stb,
    input  win_sel_t sel,
    input  logic     restart,
    output logic     tick
);

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             strobe;
    logic             tick_q;

    always_comb begin
        limit = CNT_W'(1);
        case (sel.src)
            SRC_SLOW: begin
                case (sel.step)
                    2'd0:    limit = CNT_W'(SLOW_DIV0);
                    2'd1:    limit = CNT_W'(SLOW_DIV1);
                    2'd2:    limit = CNT_W'(SLOW_DIV2);
                    default: limit = CNT_W'(SLOW_DIV3);
                endcase
            end
            SRC_FAST: begin
                case (sel.step)
                    2'd0:    limit = CNT_W'(FAST_DIV0);
                    2'd1:    limit = CNT_W'(FAST_DIV1);
                    default: limit = CNT_W'(FAST_DIV2);
                endcase
            end
            default: limit = CNT_W'(1);
        endcase
    end

    always_comb begin
        case (sel.src)
            SRC_SLOW: strobe = slow_stb;
            SRC_FAST: strobe = fast_stb;
            default:  strobe = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (strobe) begin
                if (cnt_q == limit - CNT_W'(1)) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign tick = tick_q;

    // R10: without a selected strobe the window does not advance
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!restart && !strobe) |=> (cnt_q == $past(cnt_q) && !tick_q));

    // R8: a code change clears the count and suppresses the tick
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && !tick_q));

    // R3/R4: the count stays inside the selected window
    a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
        (!restart && sel.src != SRC_OFF) |-> (cnt_q < limit));

endmodule

// File: rtl/dbn_sample_stage.sv
module dbn_sample_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic         tick,
    input  logic         restart,
    input  logic         bypass,
    output logic [W-1:0] held
);

    logic [W-1:0] prev_q;
    logic [W-1:0] held_q;
    logic         primed_q;
    logic [W-1:0] agree;
    logic [W-1:0] next_held;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign agree[b]     = ~(pins[b] ^ prev_q[b]);
        assign next_held[b] = agree[b] ? pins[b] : held_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            held_q   <= '0;
            primed_q <= 1'b0;
        end else if (bypass) begin
            prev_q   <= pins;
            held_q   <= pins;
            primed_q <= 1'b0;
        end else if (restart) begin
            primed_q <= 1'b0;
        end else if (tick) begin
            prev_q   <= pins;
            primed_q <= 1'b1;
            if (primed_q) begin
                held_q <= next_held;
            end
        end
    end

    assign held = held_q;

    // R7: filtered level holds between ticks and on a discarded tick
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!bypass && (!tick || restart)) |=> (held_q == $past(held_q)));

    // R8: the first tick after a restart only captures a reference sample
    a_r8_first_tick_primes: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !restart && tick && !primed_q) |=> (held_q == $past(held_q) && primed_q));

    // R6: a sample that matches its predecessor is taken
    a_r6_agree_taken: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !restart && tick && primed_q && pins == prev_q) |=> (held_q == $past(pins)));

endmodule

// File: rtl/dbn_nibble.sv
module dbn_nibble
    import dbn_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter int unsigned SLOW_DIV0 = 128,
    parameter int unsigned SLOW_DIV1 = 512,
    parameter int unsigned SLOW_DIV2 = 2048,
    parameter int unsigned SLOW_DIV3 = 4096,
    parameter int unsigned FAST_DIV0 = 1,
    parameter int unsigned FAST_DIV1 = 2,
    parameter int unsigned FAST_DIV2 = 4,
    parameter int unsigned CNT_W     = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slow_stb,
    input  logic         fast_stb,
    input  logic [2:0]   code,
    input  logic [W-1:0] pins,
    output logic [W-1:0] filt
);

    logic [2:0]   code_q;
    logic         restart;
    win_sel_t     sel;
    logic         bypass;
    logic         tick;
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 3'b000;
        end else begin
            code_q <= code;
        end
    end

    assign restart = (code != code_q);
    assign sel     = decode_code(code);
    assign bypass  = (sel.src == SRC_OFF);

    dbn_window_timer #(
        .SLOW_DIV0 (SLOW_DIV0),
        .SLOW_DIV1 (SLOW_DIV1),
        .SLOW_DIV2 (SLOW_DIV2),
        .SLOW_DIV3 (SLOW_DIV3),
        .FAST_DIV0 (FAST_DIV0),
        .FAST_DIV1 (FAST_DIV1),
        .FAST_DIV2 (FAST_DIV2),
        .CNT_W     (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .slow_stb (slow_stb),
        .fast_stb (fast_stb),
        .sel      (sel),
        .restart  (restart),
        .tick     (tick)
    );

    dbn_sample_stage #(
        .W (W)
    ) stage_i (
        .clk     (clk),
        .rst     (rst),
        .pins    (pins),
        .tick    (tick),
        .restart (restart),
        .bypass  (bypass),
        .held    (held)
    );

    assign filt = bypass ? pins : held;

    // R2: the off code passes the pins straight through
    a_r2_bypass_through: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b000) |-> (filt == pins));

endmodule

// File: rtl/dual_nibble_debounce.sv
module dual_nibble_debounce
    import dbn_pkg::*;
#(
    parameter int unsigned GROUPS    = 2,
    parameter int unsigned GROUP_W   = 4,
    parameter int unsigned SLOW_DIV0 = 128,
    parameter int unsigned SLOW_DIV1 = 512,
    parameter int unsigned SLOW_DIV2 = 2048,
    parameter int unsigned SLOW_DIV3 = 4096,
    parameter int unsigned FAST_DIV0 = 1,
    parameter int unsigned FAST_DIV1 = 2,
    parameter int unsigned FAST_DIV2 = 4,
    localparam int unsigned PINS     = GROUPS * GROUP_W,
    localparam int unsigned CODE_W   = GROUPS * 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_stb,
    input  logic              fast_stb,
    input  logic [CODE_W-1:0] win_code,
    input  logic [PINS-1:0]   pin_raw,
    output logic [PINS-1:0]   pin_clean
);

    localparam int unsigned MAX_DIV = max_u(max_u(max_u(SLOW_DIV0, SLOW_DIV1),
                                                  max_u(SLOW_DIV2, SLOW_DIV3)),
                                            max_u(max_u(FAST_DIV0, FAST_DIV1), FAST_DIV2));
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        dbn_nibble #(
            .W         (GROUP_W),
            .SLOW_DIV0 (SLOW_DIV0),
            .SLOW_DIV1 (SLOW_DIV1),
            .SLOW_DIV2 (SLOW_DIV2),
            .SLOW_DIV3 (SLOW_DIV3),
            .FAST_DIV0 (FAST_DIV0),
            .FAST_DIV1 (FAST_DIV1),
            .FAST_DIV2 (FAST_DIV2),
            .CNT_W     (CNT_W)
        ) grp_i (
            .clk      (clk),
            .rst      (rst),
            .slow_stb (slow_stb),
            .fast_stb (fast_stb),
            .code     (win_code[g*3 +: 3]),
            .pins     (pin_raw[g*GROUP_W +: GROUP_W]),
            .filt     (pin_clean[g*GROUP_W +: GROUP_W])
        );
    end

endmodule

// File: tb/dual_nibble_debounce_tb_top.sv
module dual_nibble_debounce_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       slow_stb;
    logic       fast_stb;
    logic [5:0] win_code;
    logic [7:0] pin_raw;
    logic [7:0] pin_clean;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    int fast_per = 1;
    int slow_per = 1;
    int fcnt = 0;
    int scnt = 0;

    always #10 clk = ~clk;

    dual_nibble_debounce dut_i (
        .clk       (clk),
        .rst       (rst),
        .slow_stb  (slow_stb),
        .fast_stb  (fast_stb),
        .win_code  (win_code),
        .pin_raw   (pin_raw),
        .pin_clean (pin_clean)
    );

    always @(negedge clk) begin
        fast_stb = (fcnt == 0);
        slow_stb = (scnt == 0);
        fcnt = (fcnt + 1 >= fast_per) ? 0 : fcnt + 1;
        scnt = (scnt + 1 >= slow_per) ? 0 : scnt + 1;
    end

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'b001: return 128;
            3'b010: return 512;
            3'b011: return 2048;
            3'b100: return 4096;
            3'b101: return 1;
            3'b110: return 2;
            3'b111: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_fast(input logic [2:0] c);
        return c >= 3'b101;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] grp(input logic [7:0] v, input int g);
        return v[g*4 +: 4];
    endfunction

    task automatic set_grp(input int g, input logic [3:0] v);
        pin_raw[g*4 +: 4] = v;
    endtask

    task automatic set_code(input int g, input logic [2:0] c);
        win_code[g*3 +: 3] = c;
    endtask

    // window length in clk cycles for group g's code
    function automatic int win_cycles(input logic [2:0] c);
        return ratio_of(c) * (is_fast(c) ? fast_per : slow_per);
    endfunction

    task automatic settle(input int g, input string req);
        int tc;
        logic [3:0] base;
        tc = win_cycles(win_code[g*3 +: 3]);
        base = grp(pin_raw, g);
        repeat (4 * tc + 8) @(negedge clk);
        #1;
        chk(grp(pin_clean, g) == base, req, {4'h0, grp(pin_clean, g)}, {4'h0, base});
    endtask

    // pulse lasting exactly one window: must be removed
    task automatic glitch(input int g, input logic [3:0] mask, input int len, input string req);
        logic [3:0] base;
        bit ok;
        logic [3:0] bad;
        int tc;
        tc = win_cycles(win_code[g*3 +: 3]);
        base = grp(pin_raw, g);
        ok = 1'b1;
        bad = base;
        @(negedge clk);
        set_grp(g, base ^ mask);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (grp(pin_clean, g) != base) begin ok = 1'b0; bad = grp(pin_clean, g); end
        end
        set_grp(g, base);
        for (int i = 0; i < 3 * tc + 4; i++) begin
            @(negedge clk);
            if (grp(pin_clean, g) != base) begin ok = 1'b0; bad = grp(pin_clean, g); end
        end
        chk(ok, req, {4'h0, bad}, {4'h0, base});
    endtask

    // level held for len cycles (>= two windows): must be taken by the end
    task automatic step(input int g, input logic [3:0] mask, input int len, input string req);
        logic [3:0] nv;
        nv = grp(pin_raw, g) ^ mask;
        @(negedge clk);
        set_grp(g, nv);
        repeat (len) @(negedge clk);
        #1;
        chk(grp(pin_clean, g) == nv, req, {4'h0, grp(pin_clean, g)}, {4'h0, nv});
    endtask

    task automatic code_run(input int g, input logic [2:0] c, input logic [3:0] mask, input string req);
        int tc;
        @(negedge clk);
        set_code(g, c);
        settle(g, req);
        tc = win_cycles(c);
        glitch(g, mask, tc, {req, " R5 one-window pulse"});
        step(g, mask, 2 * tc, {req, " R6 two-window hold"});
    endtask

    initial begin
        logic [7:0] v;
        logic [3:0] lo_old;
        logic [3:0] hi_old;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        win_code = 6'b101_101;
        pin_raw  = 8'hFF;
        fast_stb = 1'b0;
        slow_stb = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state with non-zero codes
        chk(pin_clean == 8'h00, "R1 reset state", pin_clean, 8'h00);
        pin_raw = 8'h00;
        repeat (10) @(negedge clk);
        #1;
        chk(pin_clean == 8'h00, "R1 still low after reset", pin_clean, 8'h00);

        // R2: bypass on both groups
        win_code = 6'b000_000;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            v = 8'($urandom);
            pin_raw = v;
            #1;
            chk(pin_clean == v, "R2 bypass pass-through", pin_clean, v);
        end
        @(negedge clk);
        pin_raw = 8'h00;

        // R3: fast codes with fast strobe every cycle
        code_run(0, 3'b101, 4'hF, "R3 code 101");
        code_run(0, 3'b110, 4'h5, "R3 code 110");
        code_run(0, 3'b111, 4'hA, "R3 code 111");
        // R4: slow codes with slow strobe every cycle
        code_run(0, 3'b001, 4'h3, "R4 code 001");
        code_run(0, 3'b010, 4'hC, "R4 code 010");
        code_run(0, 3'b011, 4'h9, "R4 code 011");
        code_run(0, 3'b100, 4'h6, "R4 code 100");

        // R10: off-source strobe runs faster than the selected one
        fast_per = 3;
        slow_per = 1;
        code_run(1, 3'b111, 4'hF, "R10 fast window, slow strobe busy");
        fast_per = 1;
        slow_per = 2;
        code_run(1, 3'b001, 4'h7, "R10 slow window, fast strobe busy");
        slow_per = 1;

        // R9: groups run different codes side by side
        @(negedge clk);
        set_code(0, 3'b001);
        set_code(1, 3'b101);
        settle(0, "R9 low group settle");
        settle(1, "R9 high group settle");
        lo_old = grp(pin_raw, 0);
        hi_old = grp(pin_raw, 1);
        @(negedge clk);
        pin_raw = ~pin_raw;
        repeat (8) @(negedge clk);
        #1;
        chk(grp(pin_clean, 1) == ~hi_old, "R9 high group took new level", pin_clean, {~hi_old, lo_old});
        chk(grp(pin_clean, 0) == lo_old, "R9 low group still filtering", pin_clean, {~hi_old, lo_old});
        @(negedge clk);
        set_code(1, 3'b000);
        repeat (3) @(negedge clk);
        #1;
        chk(grp(pin_clean, 0) == lo_old, "R9 high code change leaves low group", pin_clean, {~hi_old, lo_old});
        @(negedge clk);
        pin_raw = 8'h00;
        set_code(0, 3'b101);
        set_code(1, 3'b101);
        settle(0, "R9 restore low");

        // R8: code change on the cycle a tick is due, with pins changing too
        @(negedge clk);
        set_code(0, 3'b110);
        set_grp(0, 4'hF);
        repeat (5) @(negedge clk);
        #1;
        chk(grp(pin_clean, 0) == 4'h0, "R8 held through discarded and priming ticks", pin_clean, 8'h00);
        repeat (3) @(negedge clk);
        #1;
        chk(grp(pin_clean, 0) == 4'hF, "R8 taken after new window", pin_clean, 8'h0F);

        // R5/R6/R7: random pulses on fast codes
        for (int i = 0; i < 30; i++) begin
            int g;
            logic [2:0] c;
            logic [3:0] m;
            int tc;
            g = int'($urandom_range(0, 1));
            c = 3'(3'b101 + $urandom_range(0, 2));
            fast_per = int'($urandom_range(1, 3));
            m = 4'($urandom_range(1, 15));
            @(negedge clk);
            set_code(g, c);
            settle(g, "R7 random settle");
            tc = win_cycles(c);
            if ($urandom_range(0, 1) == 0)
                glitch(g, m, int'($urandom_range(1, tc)), "R5 random short pulse");
            else
                step(g, m, 2 * tc + int'($urandom_range(0, tc)), "R6 random long hold");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule